// File: doc/BRIEF.md
# Partial Field Word Transfer Unit

This block moves a chosen range of bytes between a memory word and a register word. Words use sign-magnitude form: one sign bit and five 6-bit bytes. Byte 1 is the most significant byte and byte 5 the least significant. A one-byte field spec names a first and a last position, where position 0 is the sign and positions 1 to 5 are the bytes.

In load mode the selected bytes of the memory word are moved to the low end of the result. The sign is copied only when the field starts at position 0, and an optional negate inverts the sign of the result. In store mode the memory word is rebuilt so that only the selected positions take their values from the register word. The rightmost bytes of the register fill those positions, and all other bytes and the sign keep their memory values.

The caller presents both words, the spec and the mode together with a one-cycle start strobe. The result, with an invalid-spec flag, is registered and marked by a one-cycle valid pulse on the next clock. Memory arrays and instruction decoding belong to the surrounding datapath.

Top module: `fldxfer_unit`

## Requirements
- R1: A word is 31 bits. Bit 30 is the sign (1 means negative), and byte k (1 to 5) occupies bits [35-6k : 30-6k], so byte 1 is bits 29:24 and byte 5 is bits 5:0.
- R2: The spec is F = 8*L + R, with L = spec[5:3] and R = spec[2:0]. A spec with L > R or R > 5 is invalid. An invalid spec raises spec_err_o with the result, and the result is then +0 for a load and the unchanged memory word for a store.
- R3: A valid load places memory bytes max(L,1)..R in the lowest result bytes, keeping their order, and fills the higher bytes with zero. A spec with R = 0 gives a zero magnitude.
- R4: For a load without negate, the result sign equals the memory sign when L = 0, and is positive when L > 0.
- R5: For a load with negate, the sign that R4 gives is inverted. This applies to zero magnitudes too, so -0 and +0 stay distinct in the result.
- R6: A valid store with L > 0 writes the rightmost R-L+1 register bytes into memory positions L..R. All other bytes and the memory sign pass through unchanged.
- R7: A valid store with L = 0 takes the register sign and the rightmost R register bytes into positions 1..R. The negate input has no effect in store mode.
- R8: valid_o is high exactly in the cycle after a cycle with start_i high. result_o and spec_err_o change only on such a clock and hold their values otherwise.
- R9: After synchronous reset, valid_o is 0, spec_err_o is 0 and result_o is all zeros (+0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request strobe |
| store_i | input | 1 | 1 selects store (insert), 0 selects load (extract) |
| negate_i | input | 1 | Invert the loaded sign (load only) |
| spec_i | input | 6 | Field spec F = 8*L + R |
| mem_word_i | input | 31 | Memory-side word |
| reg_word_i | input | 31 | Register-side word (store source) |
| result_o | output | 31 | Registered result word |
| spec_err_o | output | 1 | Registered invalid-spec flag |
| valid_o | output | 1 | One-cycle result strobe |

## Verification
The memory word is negative and holds the distinct byte values 1 to 5, and the register word is positive and holds 10 to 50. With these values every byte in a result shows which source and which position it came from, and which sign was chosen. Loads cover the full word, sign-only, single-byte, sign-plus-prefix and negated fields, and separate right-justification from in-place copying. Stores cover full, interior, edge and sign-only fields, and show whether untouched bytes and the sign survive. Invalid specs, a negated zero and the hold behaviour between strobes cover the remaining corner cases.

// File: rtl/fldx_pkg.sv
package fldx_pkg;

    localparam int BYTE_W = 6;
    localparam int NBYTES = 5;
    localparam int MAG_W  = BYTE_W * NBYTES;
    localparam int WORD_W = MAG_W + 1;
    localparam int IDX_W  = 3;
    localparam int SPEC_W = 2 * IDX_W;

    typedef struct packed {
        logic             neg;
        logic [MAG_W-1:0] mag;
    } fword_t;

    typedef struct packed {
        logic             ok;
        logic [IDX_W-1:0] lo;
        logic [IDX_W-1:0] hi;
        logic [IDX_W-1:0] first;
        logic [IDX_W-1:0] count;
        logic [IDX_W-1:0] shift;
    } fspec_t;

    // Mask covering the lowest 'n' bytes of a magnitude.
    function automatic logic [MAG_W-1:0] low_bytes(input logic [IDX_W-1:0] n);
        logic [MAG_W-1:0] m;
        m = '0;
        for (int b = 0; b < NBYTES; b++) begin
            if (b < int'(n)) m[b*BYTE_W +: BYTE_W] = '1;
        end
        return m;
    endfunction

endpackage

// File: rtl/fldx_spec_dec.sv
module fldx_spec_dec
    import fldx_pkg::*;
(
    input  logic [SPEC_W-1:0] spec_i,
    output fspec_t            dec_o
);
    logic [IDX_W-1:0] lo, hi, first;
    logic             ok;

    always_comb begin
        lo    = spec_i[SPEC_W-1:IDX_W];
        hi    = spec_i[IDX_W-1:0];
        ok    = (lo <= hi) && (hi <= IDX_W'(NBYTES));
        first = (lo == '0) ? IDX_W'(1) : lo;

        dec_o       = '0;
        dec_o.ok    = ok;
        dec_o.lo    = lo;
        dec_o.hi    = hi;
        dec_o.first = first;
        if (ok) begin
            dec_o.count = (hi >= first) ? (hi - first + IDX_W'(1)) : '0;
            dec_o.shift = IDX_W'(NBYTES) - hi;
        end
    end
endmodule

// File: rtl/fldx_extract.sv
module fldx_extract
    import fldx_pkg::*;
(
    input  fword_t mem_i,
    input  fspec_t dec_i,
    input  logic   negate_i,
    output fword_t out_o
);
    logic [MAG_W-1:0] shifted;
    logic             base_sign;

    always_comb begin
        shifted   = mem_i.mag >> (BYTE_W * int'(dec_i.shift));
        base_sign = (dec_i.lo == '0) ? mem_i.neg : 1'b0;
        out_o     = '0;
        if (dec_i.ok) begin
            out_o.mag = shifted & low_bytes(dec_i.count);
            out_o.neg = base_sign ^ negate_i;
        end
    end
endmodule

// File: rtl/fldx_insert.sv
module fldx_insert
    import fldx_pkg::*;
(
    input  fword_t mem_i,
    input  fword_t reg_i,
    input  fspec_t dec_i,
    output fword_t out_o
);
    logic [MAG_W-1:0] aligned;
    logic [MAG_W-1:0] merged;

    assign aligned = reg_i.mag << (BYTE_W * int'(dec_i.shift));

    // One selector per byte position; position k sits at bits [(NBYTES-k)*BYTE_W +: BYTE_W].
    for (genvar k = 1; k <= NBYTES; k++) begin : g_pos
        localparam logic [IDX_W-1:0] KI = IDX_W'(k);
        localparam int LSB = (NBYTES - k) * BYTE_W;
        logic take;
        assign take = dec_i.ok && (KI >= dec_i.first) && (KI <= dec_i.hi);
        assign merged[LSB +: BYTE_W] = take ? aligned[LSB +: BYTE_W] : mem_i.mag[LSB +: BYTE_W];
    end

    always_comb begin
        out_o.mag = merged;
        out_o.neg = (dec_i.ok && dec_i.lo == '0) ? reg_i.neg : mem_i.neg;
    end
endmodule

// File: rtl/fldxfer_unit.sv
module fldxfer_unit
    import fldx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              store_i,
    input  logic              negate_i,
    input  logic [SPEC_W-1:0] spec_i,
    input  logic [WORD_W-1:0] mem_word_i,
    input  logic [WORD_W-1:0] reg_word_i,
    output logic [WORD_W-1:0] result_o,
    output logic              spec_err_o,
    output logic              valid_o
);
    fspec_t dec;
    fword_t mem_w, reg_w, ld_w, st_w, res_q;

    assign mem_w = fword_t'(mem_word_i);
    assign reg_w = fword_t'(reg_word_i);

    fldx_spec_dec u_dec (.spec_i(spec_i), .dec_o(dec));
    fldx_extract  u_ext (.mem_i(mem_w), .dec_i(dec), .negate_i(negate_i), .out_o(ld_w));
    fldx_insert   u_ins (.mem_i(mem_w), .reg_i(reg_w), .dec_i(dec), .out_o(st_w));

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q      <= '0;
            spec_err_o <= 1'b0;
            valid_o    <= 1'b0;
        end else begin
            valid_o <= start_i;
            if (start_i) begin
                res_q      <= store_i ? st_w : ld_w;
                spec_err_o <= !dec.ok;
            end
        end
    end

    assign result_o = res_q;

    // R8: strobe timing and hold
    a_r8_valid_after_start: assert property (@(posedge clk) disable iff (rst)
        start_i |=> valid_o);
    a_r8_quiet_without_start: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> !valid_o);
    a_r8_result_held: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> $stable(result_o) && $stable(spec_err_o));

    // R2: out-of-range spec reported
    a_r2_bad_spec_flagged: assert property (@(posedge clk) disable iff (rst)
        (start_i && spec_i[2:0] > 3'd5) |=> spec_err_o);

    // R4: load with field past the sign yields a positive result
    a_r4_load_sign_plus: assert property (@(posedge clk) disable iff (rst)
        (start_i && !store_i && !negate_i && spec_i[5:3] != 3'd0) |=> !result_o[WORD_W-1]);

    // R6: store not touching position 0 keeps memory sign
    a_r6_store_keeps_sign: assert property (@(posedge clk) disable iff (rst)
        (start_i && store_i && spec_i[5:3] != 3'd0) |=> result_o[WORD_W-1] == $past(mem_word_i[WORD_W-1]));

endmodule

// File: tb/sim_fldxfer_unit.sv
module sim_fldxfer_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        store_i = 1'b0;
    logic        negate_i = 1'b0;
    logic [5:0]  spec_i = '0;
    logic [30:0] mem_word_i = '0;
    logic [30:0] reg_word_i = '0;
    logic [30:0] result_o;
    logic        spec_err_o;
    logic        valid_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    fldxfer_unit u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .store_i(store_i),
        .negate_i(negate_i), .spec_i(spec_i), .mem_word_i(mem_word_i),
        .reg_word_i(reg_word_i), .result_o(result_o),
        .spec_err_o(spec_err_o), .valid_o(valid_o)
    );

    // R1 layout: {sign, byte1 .. byte5}
    localparam logic [30:0] MW = {1'b1, 6'd1, 6'd2, 6'd3, 6'd4, 6'd5};
    localparam logic [30:0] RW = {1'b0, 6'd10, 6'd20, 6'd30, 6'd40, 6'd50};
    localparam int NV = 17;

    // {store, negate, spec, mem, reg, expected, expected_err}
    localparam logic [101:0] VECS [NV] = '{
        {1'b0, 1'b0, 6'd5,  MW, RW, MW, 1'b0},                                        // R3 R4 full
        {1'b0, 1'b0, 6'd13, MW, RW, {1'b0, 6'd1, 6'd2, 6'd3, 6'd4, 6'd5}, 1'b0},      // R4 no sign
        {1'b0, 1'b0, 6'd27, MW, RW, {1'b0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd3}, 1'b0},      // R3 single byte
        {1'b0, 1'b0, 6'd2,  MW, RW, {1'b1, 6'd0, 6'd0, 6'd0, 6'd1, 6'd2}, 1'b0},      // R3 sign+prefix
        {1'b0, 1'b0, 6'd0,  MW, RW, {1'b1, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0}, 1'b0},      // R3 sign only
        {1'b0, 1'b1, 6'd5,  MW, RW, {1'b0, 6'd1, 6'd2, 6'd3, 6'd4, 6'd5}, 1'b0},      // R5
        {1'b0, 1'b1, 6'd37, MW, RW, {1'b1, 6'd0, 6'd0, 6'd0, 6'd4, 6'd5}, 1'b0},      // R5
        {1'b0, 1'b0, 6'd45, MW, RW, {1'b0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd5}, 1'b0},      // R3
        {1'b1, 1'b0, 6'd5,  MW, RW, RW, 1'b0},                                        // R7 full
        {1'b1, 1'b0, 6'd13, MW, RW, {1'b1, 6'd10, 6'd20, 6'd30, 6'd40, 6'd50}, 1'b0}, // R6
        {1'b1, 1'b0, 6'd19, MW, RW, {1'b1, 6'd1, 6'd40, 6'd50, 6'd4, 6'd5}, 1'b0},    // R6 interior
        {1'b1, 1'b0, 6'd0,  MW, RW, {1'b0, 6'd1, 6'd2, 6'd3, 6'd4, 6'd5}, 1'b0},      // R7 sign only
        {1'b1, 1'b0, 6'd45, MW, RW, {1'b1, 6'd1, 6'd2, 6'd3, 6'd4, 6'd50}, 1'b0},     // R6 last byte
        {1'b1, 1'b1, 6'd1,  MW, RW, {1'b0, 6'd50, 6'd2, 6'd3, 6'd4, 6'd5}, 1'b0},     // R7 negate ignored
        {1'b0, 1'b0, 6'd26, MW, RW, 31'd0, 1'b1},                                     // R2 L>R load
        {1'b1, 1'b0, 6'd22, MW, RW, MW, 1'b1},                                        // R2 R>5 store
        {1'b0, 1'b1, 6'd36, MW, RW, {1'b1, 6'd0, 6'd0, 6'd0, 6'd0, 6'd4}, 1'b0}       // R5 negate of plus
    };

    task automatic check(input string req, input logic [30:0] got, input logic [30:0] exp,
                         input logic gerr, input logic eerr, input logic gv, input logic ev);
        checks++;
        if (got !== exp || gerr !== eerr || gv !== ev) begin
            fails++;
            $display("FAIL %s: result=%h err=%b valid=%b expected result=%h err=%b valid=%b",
                     req, got, gerr, gv, exp, eerr, ev);
        end
    endtask

    task automatic apply(input logic st, input logic ng, input logic [5:0] sp,
                         input logic [30:0] mw, input logic [30:0] rw);
        @(negedge clk);
        store_i = st; negate_i = ng; spec_i = sp;
        mem_word_i = mw; reg_word_i = rw; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: result=%h expected completion", result_o);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        check("R9", result_o, 31'd0, spec_err_o, 1'b0, valid_o, 1'b0);

        for (int i = 0; i < NV; i++) begin
            logic [101:0] v;
            string req;
            v = VECS[i];
            apply(v[101], v[100], v[99:94], v[93:63], v[62:32]);
            if (v[0]) req = "R2";
            else if (v[101]) req = "R6/R7";
            else req = "R3/R4/R5";
            check(req, result_o, v[31:1], spec_err_o, v[0], valid_o, 1'b1);
        end

        // R8: one cycle later valid drops and result holds despite input changes
        mem_word_i = RW; spec_i = 6'd26; store_i = 1'b1;
        @(negedge clk);
        check("R8", result_o, {1'b1, 6'd0, 6'd0, 6'd0, 6'd0, 6'd4}, spec_err_o, 1'b0, valid_o, 1'b0);

        // R5: negated load of +0 gives -0
        apply(1'b0, 1'b1, 6'd5, 31'd0, RW);
        check("R5", result_o, {1'b1, 30'd0}, spec_err_o, 1'b0, valid_o, 1'b1);

        // R4: -0 source loaded whole keeps negative sign
        apply(1'b0, 1'b0, 6'd5, {1'b1, 30'd0}, RW);
        check("R4", result_o, {1'b1, 30'd0}, spec_err_o, 1'b0, valid_o, 1'b1);

        // R9: reset clears a held result
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R9", result_o, 31'd0, spec_err_o, 1'b0, valid_o, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule